// File: doc/BRIEF.md
# Single-Wire Bus Reset and Presence Sequencer

This block sits on the master side of an open-drain single-wire serial bus. It puts the attached slave through a reset and then confirms that the slave answers, before any command traffic is allowed. A start request first holds the line low for a reset pulse. If the host says the slave is still busy with an earlier command, the pulse uses a longer discharge interval instead, which drains the slave's internal energy store. The line is then released for a recovery interval. After that the block sends a short discovery pulse. An attached slave stretches this pulse with its own acknowledge low.

The block samples the line through a two-flop synchronizer at a fixed cycle offset inside the discovery window. A low level at that point means a slave is present. The block then waits until the line has been seen high for a full start/stop hold interval. Only then does it raise `done`, with the `present` result valid beside it. The line is modelled as an active-high pull-low enable, `lineDriveLow`, plus the raw line level, `lineIn`. Every interval is a parameter given in clock cycles.

Top module: `swire_discovery_seq`

## Requirements
- R1: After reset, `lineDriveLow`, `done` and `present` are all 0.
- R2: When `startReq` is sampled high while idle and `slaveBusy` is 0, `lineDriveLow` goes high in the next cycle and stays high for exactly RESET_CYC cycles.
- R3: When `slaveBusy` is 1 as the start is accepted, the reset pulse lasts exactly DISCHARGE_CYC cycles. `slaveBusy` is read only at that acceptance edge.
- R4: After the reset pulse, `lineDriveLow` stays low for exactly RECOVER_CYC cycles.
- R5: The discovery pulse then holds `lineDriveLow` high for exactly DISC_DRIVE_CYC cycles. The line is not driven again in that sequence.
- R6: Number the discovery cycles from 0, where cycle 0 is the first cycle of the discovery pulse. `present` becomes 1 exactly when `lineIn` was low in cycle SAMPLE_AT_CYC-2 of that count. This is the synchronized sample taken in cycle SAMPLE_AT_CYC.
- R7: Let L be the number of discovery cycles in which the line is held low, counted from cycle 0. Let S be SAMPLE_AT_CYC. `done` rises in discovery cycle max(S+1, L+2) + HOLD_CYC, which is after the synchronized line has been high for HOLD_CYC consecutive cycles.
- R8: When no slave answers, `present` is 0, and `done` still rises only after the full hold phase.
- R9: A `startReq` that arrives while a sequence runs is ignored. Pulse lengths and `done` timing are unchanged, and no new pulse follows completion.
- R10: `done` and `present` are cleared in the cycle after a new start is accepted. After completion both hold their values until that happens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| startReq | input | 1 | Request to run a reset and discovery sequence |
| slaveBusy | input | 1 | Slave is executing a command; select the long discharge pulse |
| lineIn | input | 1 | Raw level of the bus line, asynchronous |
| lineDriveLow | output | 1 | 1 pulls the open-drain line low |
| done | output | 1 | Sequence finished; holds until the next accepted start |
| present | output | 1 | Slave acknowledge detected; valid while `done` is 1 |

## Verification
A modelled slave answers each discovery pulse with an acknowledge whose length is swept from 0 up to well past the sampling point, with the busy flag both clear and set. The short acknowledges separate the presence decision on either side of the sampling cycle: a length of SAMPLE_AT_CYC-2 must read as absent and SAMPLE_AT_CYC-1 as present. The long acknowledges show that the hold phase waits for the line to come back high, not just for a fixed time. Extra start requests and a toggled busy flag are injected during the reset pulse and during the hold phase. These runs confirm that neither the pulse lengths nor the completion time move.

// File: rtl/swdisc_pkg.sv
package swdisc_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_RESET,
    PH_RECOVER,
    PH_DISCOVER,
    PH_HOLD
  } phase_e;

  typedef struct packed {
    logic cntClr;
    logic sampleEn;
    logic presClr;
  } dpStrobe_t;

endpackage

// File: rtl/swdisc_dpath.sv
module swdisc_dpath
  import swdisc_pkg::*;
#(
  parameter int CW = 8
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpStrobe_t     strobe,
  input  logic          lineIn,
  output logic [CW-1:0] cnt,
  output logic          lineSync,
  output logic          present
);

  localparam int SYNC_STAGES = 2;

  logic [SYNC_STAGES-1:0] syncQ;

  // Two-flop synchronizer; the idle bus rests high through its pull-up.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) syncQ <= '1;
    else       syncQ <= {syncQ[SYNC_STAGES-2:0], lineIn};
  end
  assign lineSync = syncQ[SYNC_STAGES-1];

  // Shared phase counter, cleared by control on every phase change.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              cnt <= '0;
    else if (strobe.cntClr) cnt <= '0;
    else                    cnt <= cnt + 1'b1;
  end

  // Presence flag: a low line at the sample point means an acknowledge.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                present <= 1'b0;
    else if (strobe.presClr)  present <= 1'b0;
    else if (strobe.sampleEn) present <= ~lineSync;
  end

  // R6: exactly one sample is taken per discovery window
  a_r6_single_sample: assert property (@(posedge clk) disable iff (!rstN)
    strobe.sampleEn |=> !strobe.sampleEn);

endmodule

// File: rtl/swdisc_ctrl.sv
module swdisc_ctrl
  import swdisc_pkg::*;
#(
  parameter int CW             = 8,
  parameter int RESET_CYC      = 8,
  parameter int DISCHARGE_CYC  = 20,
  parameter int RECOVER_CYC    = 5,
  parameter int DISC_DRIVE_CYC = 3,
  parameter int SAMPLE_AT_CYC  = 7,
  parameter int HOLD_CYC       = 6
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          startReq,
  input  logic          slaveBusy,
  input  logic [CW-1:0] cnt,
  input  logic          lineSync,
  output dpStrobe_t     strobe,
  output logic          lineDriveLow,
  output logic          done
);

  localparam logic [CW-1:0] RST_LAST   = CW'(RESET_CYC - 1);
  localparam logic [CW-1:0] DSCHG_LAST = CW'(DISCHARGE_CYC - 1);
  localparam logic [CW-1:0] REC_LAST   = CW'(RECOVER_CYC - 1);
  localparam logic [CW-1:0] DRIVE_END  = CW'(DISC_DRIVE_CYC);
  localparam logic [CW-1:0] SAMPLE_PT  = CW'(SAMPLE_AT_CYC);
  localparam logic [CW-1:0] HOLD_LAST  = CW'(HOLD_CYC - 1);

  phase_e        phase, nxtPhase;
  logic          longRst;
  logic [CW-1:0] rstLast;

  assign rstLast = longRst ? DSCHG_LAST : RST_LAST;

  always_comb begin
    nxtPhase = phase;
    strobe   = '0;
    unique case (phase)
      PH_IDLE: begin
        strobe.cntClr = 1'b1;
        if (startReq) begin
          nxtPhase       = PH_RESET;
          strobe.presClr = 1'b1;
        end
      end
      PH_RESET: begin
        if (cnt == rstLast) begin
          nxtPhase      = PH_RECOVER;
          strobe.cntClr = 1'b1;
        end
      end
      PH_RECOVER: begin
        if (cnt == REC_LAST) begin
          nxtPhase      = PH_DISCOVER;
          strobe.cntClr = 1'b1;
        end
      end
      PH_DISCOVER: begin
        if (cnt == SAMPLE_PT) begin
          nxtPhase        = PH_HOLD;
          strobe.sampleEn = 1'b1;
          strobe.cntClr   = 1'b1;
        end
      end
      PH_HOLD: begin
        if (!lineSync) begin
          strobe.cntClr = 1'b1;
        end else if (cnt == HOLD_LAST) begin
          nxtPhase      = PH_IDLE;
          strobe.cntClr = 1'b1;
        end
      end
      default: nxtPhase = PH_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= PH_IDLE;
      longRst <= 1'b0;
      done    <= 1'b0;
    end else begin
      phase <= nxtPhase;
      if (phase == PH_IDLE && startReq) begin
        longRst <= slaveBusy;
        done    <= 1'b0;
      end else if (phase == PH_HOLD && nxtPhase == PH_IDLE) begin
        done <= 1'b1;
      end
    end
  end

  assign lineDriveLow = (phase == PH_RESET) ||
                        (phase == PH_DISCOVER && cnt < DRIVE_END);

  // R9: the reset phase is entered only from idle
  a_r9_start_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (phase != PH_IDLE) |=> (phase != PH_RESET || $past(phase) == PH_RESET));

  // R10: an accepted start clears the completion flag
  a_r10_done_clears: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE && startReq) |=> (!done && phase == PH_RESET));

  // R7: completion follows a cycle where the synchronized line was high
  a_r7_done_after_high: assert property (@(posedge clk) disable iff (!rstN)
    $rose(done) |-> $past(lineSync));

  // R8: the hold phase always follows the sample
  a_r8_hold_after_sample: assert property (@(posedge clk) disable iff (!rstN)
    $past(strobe.sampleEn) |-> (phase == PH_HOLD));

endmodule

// File: rtl/swire_discovery_seq.sv
module swire_discovery_seq
  import swdisc_pkg::*;
#(
  parameter int RESET_CYC      = 960,
  parameter int DISCHARGE_CYC  = 1500,
  parameter int RECOVER_CYC    = 80,
  parameter int DISC_DRIVE_CYC = 10,
  parameter int SAMPLE_AT_CYC  = 20,
  parameter int HOLD_CYC       = 20
) (
  input  logic clk,
  input  logic rstN,
  input  logic startReq,
  input  logic slaveBusy,
  input  logic lineIn,
  output logic lineDriveLow,
  output logic done,
  output logic present
);

  localparam int M1     = (RESET_CYC > DISCHARGE_CYC) ? RESET_CYC : DISCHARGE_CYC;
  localparam int M2     = (M1 > RECOVER_CYC) ? M1 : RECOVER_CYC;
  localparam int M3     = (M2 > SAMPLE_AT_CYC + 1) ? M2 : SAMPLE_AT_CYC + 1;
  localparam int MAXLEN = (M3 > HOLD_CYC) ? M3 : HOLD_CYC;
  localparam int CW     = $clog2(MAXLEN + 1);

  initial begin
    if (SAMPLE_AT_CYC < DISC_DRIVE_CYC + 2)
      $error("SAMPLE_AT_CYC must leave room for the synchronizer after the drive");
  end

  dpStrobe_t     strobe;
  logic [CW-1:0] cnt;
  logic          lineSync;

  swdisc_ctrl #(
    .CW(CW), .RESET_CYC(RESET_CYC), .DISCHARGE_CYC(DISCHARGE_CYC),
    .RECOVER_CYC(RECOVER_CYC), .DISC_DRIVE_CYC(DISC_DRIVE_CYC),
    .SAMPLE_AT_CYC(SAMPLE_AT_CYC), .HOLD_CYC(HOLD_CYC)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .slaveBusy(slaveBusy),
    .cnt(cnt), .lineSync(lineSync), .strobe(strobe),
    .lineDriveLow(lineDriveLow), .done(done)
  );

  swdisc_dpath #(.CW(CW)) dpath_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .lineIn(lineIn),
    .cnt(cnt), .lineSync(lineSync), .present(present)
  );

  // R10: once finished, the result holds until a new start
  a_r10_present_holds: assert property (@(posedge clk) disable iff (!rstN)
    (done && !startReq) |=> $stable(present));

endmodule

// File: tb/swire_discovery_seq_tb.sv
module swire_discovery_seq_tb_top;

  localparam int CLK_PERIOD = 10;
  localparam int P_RST   = 8;
  localparam int P_DSCHG = 20;
  localparam int P_REC   = 5;
  localparam int P_DRV   = 3;
  localparam int P_SMP   = 7;
  localparam int P_HOLD  = 6;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic startReq = 1'b0;
  logic slaveBusy = 1'b0;
  logic slaveLow = 1'b0;
  logic lineIn;
  logic lineDriveLow, done, present;

  int vectors = 0;
  int miscompares = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // open-drain bus: master or slave may pull low
  assign lineIn = ~(lineDriveLow | slaveLow);

  swire_discovery_seq #(
    .RESET_CYC(P_RST), .DISCHARGE_CYC(P_DSCHG), .RECOVER_CYC(P_REC),
    .DISC_DRIVE_CYC(P_DRV), .SAMPLE_AT_CYC(P_SMP), .HOLD_CYC(P_HOLD)
  ) dut_i (
    .clk(clk), .rstN(rstN), .startReq(startReq), .slaveBusy(slaveBusy),
    .lineIn(lineIn), .lineDriveLow(lineDriveLow), .done(done), .present(present)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      miscompares++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic runSeq(input bit busy, input int ack, input bit inject);
    int st = 1, p1 = 0, gap = 0, p2 = 0, k = 0, doneK = -1;
    int lowLen, expDone;
    bit fin = 0;
    @(negedge clk);
    startReq = 1'b1;
    slaveBusy = busy;
    @(negedge clk);
    startReq = 1'b0;
    chk(done == 1'b0 && present == 1'b0, "R10 clear on start", {done, present}, 0);
    for (int it = 0; it < 400 && !fin; it++) begin
      if (it > 0) @(negedge clk);
      unique case (st)
        1: if (lineDriveLow) p1++; else begin st = 2; gap = 1; end
        2: if (!lineDriveLow) gap++; else begin st = 3; k = 0; p2 = 1; end
        default: begin
          k++;
          if (lineDriveLow) p2++;
          if (done) begin doneK = k; fin = 1; end
        end
      endcase
      if (st == 3) slaveLow = (k < ack);
      startReq = inject && (it == 2 || (st == 3 && k == P_SMP + 2));
      if (inject && it == 2) slaveBusy = ~busy;
    end
    slaveLow = 1'b0;
    startReq = 1'b0;
    lowLen  = (ack > P_DRV) ? ack : P_DRV;
    expDone = ((P_SMP + 1 > lowLen + 2) ? P_SMP + 1 : lowLen + 2) + P_HOLD;
    if (busy) chk(p1 == P_DSCHG, "R3 discharge pulse", p1, P_DSCHG);
    else      chk(p1 == P_RST, "R2 reset pulse", p1, P_RST);
    chk(gap == P_REC, "R4 recovery gap", gap, P_REC);
    chk(p2 == P_DRV, "R5 discovery drive", p2, P_DRV);
    chk(present == (ack >= P_SMP - 1), "R6 presence", present, ack >= P_SMP - 1);
    if (ack < P_SMP - 1)
      chk(doneK == expDone, "R8 absent completes", doneK, expDone);
    else
      chk(doneK == expDone, "R7 done timing", doneK, expDone);
    for (int q = 0; q < 4; q++) begin
      @(negedge clk);
      chk(!lineDriveLow && done, "R9 no restart", {lineDriveLow, done}, 1);
    end
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    miscompares++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(!lineDriveLow && !done && !present, "R1 reset state",
        {lineDriveLow, done, present}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(!lineDriveLow && !done && !present, "R1 idle after reset",
        {lineDriveLow, done, present}, 0);
    for (int b = 0; b < 2; b++)
      for (int a = 0; a <= 14; a++)
        runSeq(b[0], a, 1'b0);
    // R9: stray starts and busy toggles mid-sequence
    runSeq(1'b0, 8, 1'b1);
    runSeq(1'b1, 2, 1'b1);
    runSeq(1'b0, 12, 1'b1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

endmodule